// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block fills a configuration register file from an external serial EEPROM after reset. It acts as a two-wire bus master. It performs a random-address read that starts at word address 0x80, so the 128-byte identity area below that address is never loaded. The first byte it reads is a header. A header of 0x00 means the bytes that follow are copied in order into the registers through a simple address/data write strobe. Any other header value loads a set of computed built-in defaults. A missing acknowledge from the device on any address byte also loads those defaults.

A single hold input controls access to the bus. While the hold input is high, any download in progress is abandoned at once and both bus lines are released, so another master can read or program the EEPROM. While the hold input is low, the block reloads again and again: each finished load is followed by a fixed idle gap, and then the next load begins. A sticky done flag rises after the first load that completes, whether it loaded EEPROM data or defaults.

The bus pins are open-drain style. An output of 1 pulls the line low, and an output of 0 releases it. SCL is derived from the system clock. Each bus bit takes four phase ticks of CLK_DIV clock cycles each.

Top module: `cfg_rom_loader`

## Requirements
- R1: During reset, both bus pull-downs are off, the done flag is low and the write strobe is low. When reset is released with hold low, a load begins with no other stimulus.
- R2: Each load sends a START and then 0xA0 (device address 1010000, write bit 0). It then sends word address 0x80, a repeated START and 0xA1 (same device, read bit 1). It checks the device acknowledge after each of these three bytes.
- R3: If the header byte at 0x80 is 0x00, register k receives the EEPROM byte at address 0x81+k for k = 0..NUM_REGS-1. No byte from 0x00–0x7F ever reaches a register.
- R4: If the header byte is not 0x00, the master NACKs it and sends STOP. Register k then receives DEF_SEED xor ((37·k) mod 256).
- R5: If the device does not acknowledge an address byte, the master sends STOP and the registers receive the same defaults as in R4.
- R6: The master acknowledges every byte it reads except the last one of the transfer, NACKs that last byte, and then sends STOP. Both lines are released when done rises.
- R7: Done rises only after all NUM_REGS register writes of a load have been issued. It then stays high until reset.
- R8: When hold is high, both pull-downs and the write strobe are off one cycle later. An interrupted load issues no further writes and does not raise done.
- R9: While hold stays high after reset, the block issues no bus activity and no writes. Once hold falls, a full load is carried out.
- R10: While hold stays low, each completed load is followed by a new START no sooner than GAP_CYC cycles later.
- R11: Each register write is a one-cycle strobe. Within a load, addresses run in ascending order from 0 to NUM_REGS-1, each exactly once, and never reach NUM_REGS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_i | input | 1 | 1: abort and stay off the bus; 0: load continuously |
| sda_i | input | 1 | Sensed level of the data line |
| scl_oe_o | output | 1 | 1 pulls the clock line low |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | AW | Register index being written |
| wr_data_o | output | 8 | Register value being written |
| done_o | output | 1 | Sticky: a load has completed |

## Verification
The bench builds the block with NUM_REGS=6, CLK_DIV=2 and GAP_CYC=40. With these values a whole load takes under a thousand cycles. That leaves room for five header/acknowledge combinations, an abort, a hold-at-reset case and two back-to-back continuous reloads within the cycle budget. Six registers make the address width three bits without a power of two, so the ascending-index and last-byte-NACK checks land on a register that does not sit at the end of the address range.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;

  typedef enum logic [1:0] {
    OP_START,
    OP_STOP,
    OP_WRITE,
    OP_READ
  } bus_op_e;

  typedef enum logic [3:0] {
    LD_IDLE,
    LD_START1,
    LD_DEVW,
    LD_WADDR,
    LD_START2,
    LD_DEVR,
    LD_HDR,
    LD_DATA,
    LD_STOP,
    LD_DEFS,
    LD_GAP
  } ld_state_e;

  // Built-in default for register idx: seed xor (37*idx mod 256)
  function automatic logic [7:0] dflt_byte(input logic [7:0] seed, input int unsigned idx);
    dflt_byte = seed ^ 8'((idx * 37) & 255);
  endfunction

endpackage

// File: rtl/cfg_ldr_tick.sv
module cfg_ldr_tick #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  if (DIV <= 1) begin : g_every
    assign tick = 1'b1;
  end else begin : g_div
    localparam int CW = $clog2(DIV);
    logic [CW-1:0] cnt;
    logic          tick_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt    <= '0;
        tick_q <= 1'b0;
      end else if (cnt == CW'(DIV - 1)) begin
        cnt    <= '0;
        tick_q <= 1'b1;
      end else begin
        cnt    <= cnt + 1'b1;
        tick_q <= 1'b0;
      end
    end

    assign tick = tick_q;
  end

endmodule

// File: rtl/cfg_ldr_bitio.sv
module cfg_ldr_bitio
  import cfg_ldr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       abort,
  input  logic       tick,
  input  logic       cmd_vld,
  input  bus_op_e    cmd_op,
  input  logic [7:0] cmd_tx,
  input  logic       ack_drv,
  input  logic       sda_in,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       ack_ok,
  output logic       scl_oe,
  output logic       sda_oe
);

  logic [1:0] ph;
  logic [3:0] bitn;
  bus_op_e    op;
  logic [7:0] sh;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
      ph     <= 2'd0;
      bitn   <= 4'd0;
      op     <= OP_START;
      sh     <= 8'h00;
      ack_ok <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (cmd_vld) begin
          busy <= 1'b1;
          op   <= cmd_op;
          sh   <= cmd_tx;
          ph   <= 2'd0;
          bitn <= 4'd0;
        end
      end else if (tick) begin
        ph <= ph + 2'd1;
        case (op)
          OP_START: begin
            case (ph)
              2'd0: begin scl_oe <= 1'b1; sda_oe <= 1'b0; end
              2'd1: scl_oe <= 1'b0;
              2'd2: sda_oe <= 1'b1;
              default: begin scl_oe <= 1'b1; busy <= 1'b0; done <= 1'b1; end
            endcase
          end
          OP_STOP: begin
            case (ph)
              2'd0: begin scl_oe <= 1'b1; sda_oe <= 1'b1; end
              2'd1: scl_oe <= 1'b0;
              2'd2: sda_oe <= 1'b0;
              default: begin busy <= 1'b0; done <= 1'b1; end
            endcase
          end
          default: begin
            case (ph)
              2'd0: begin
                scl_oe <= 1'b1;
                if (bitn == 4'd8) sda_oe <= (op == OP_READ) && ack_drv;
                else              sda_oe <= (op == OP_WRITE) && !sh[7];
              end
              2'd1: scl_oe <= 1'b0;
              2'd2: begin
                if (bitn == 4'd8) ack_ok <= !sda_in;
                else              sh     <= {sh[6:0], sda_in};
              end
              default: begin
                scl_oe <= 1'b1;
                if (bitn == 4'd8) begin
                  busy <= 1'b0;
                  done <= 1'b1;
                end else begin
                  bitn <= bitn + 4'd1;
                end
              end
            endcase
          end
        endcase
      end
    end
  end

  assign rx_byte = sh;

endmodule

// File: rtl/cfg_ldr_seq.sv
module cfg_ldr_seq
  import cfg_ldr_pkg::*;
#(
  parameter int          NUM_REGS  = 16,
  parameter int          AW        = 4,
  parameter int          GAP_CYC   = 1024,
  parameter logic [6:0]  DEV_ADDR  = 7'h50,
  parameter logic [7:0]  BASE_ADDR = 8'h80,
  parameter logic [7:0]  DEF_SEED  = 8'hA5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          bit_busy,
  input  logic          bit_done,
  input  logic [7:0]    rx_byte,
  input  logic          ack_ok,
  output logic          cmd_vld,
  output bus_op_e       cmd_op,
  output logic [7:0]    cmd_tx,
  output logic          ack_drv,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          done
);

  localparam int GW = (GAP_CYC > 0) ? $clog2(GAP_CYC + 1) : 1;

  ld_state_e     st;
  logic          issued;
  logic          fail;
  logic [AW-1:0] idx;
  logic [GW-1:0] gap;
  logic          bus_state;
  logic          last_idx;

  always_comb begin
    bus_state = 1'b1;
    cmd_op    = OP_WRITE;
    cmd_tx    = 8'h00;
    case (st)
      LD_START1, LD_START2: cmd_op = OP_START;
      LD_DEVW:              cmd_tx = {DEV_ADDR, 1'b0};
      LD_WADDR:             cmd_tx = BASE_ADDR;
      LD_DEVR:              cmd_tx = {DEV_ADDR, 1'b1};
      LD_HDR, LD_DATA:      cmd_op = OP_READ;
      LD_STOP:              cmd_op = OP_STOP;
      default:              bus_state = 1'b0;
    endcase
  end

  assign last_idx = (idx == AW'(NUM_REGS - 1));
  assign cmd_vld  = bus_state && !issued && !bit_busy && !hold;
  assign ack_drv  = (st == LD_HDR) ? (rx_byte == 8'h00) : !last_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= LD_IDLE;
      issued  <= 1'b0;
      fail    <= 1'b0;
      idx     <= '0;
      gap     <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= 8'h00;
      done    <= 1'b0;
    end else if (hold) begin
      st     <= LD_IDLE;
      issued <= 1'b0;
      wr_en  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (cmd_vld) issued <= 1'b1;
      case (st)
        LD_IDLE: begin
          fail <= 1'b0;
          idx  <= '0;
          st   <= LD_START1;
        end
        LD_GAP: begin
          if (gap == GW'(GAP_CYC)) begin
            fail <= 1'b0;
            idx  <= '0;
            st   <= LD_START1;
          end else begin
            gap <= gap + 1'b1;
          end
        end
        LD_DEFS: begin
          wr_en   <= 1'b1;
          wr_addr <= idx;
          wr_data <= dflt_byte(DEF_SEED, 32'(idx));
          if (last_idx) begin
            done <= 1'b1;
            gap  <= '0;
            st   <= LD_GAP;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: begin
          if (bit_done) begin
            issued <= 1'b0;
            case (st)
              LD_START1: st <= LD_DEVW;
              LD_DEVW: begin
                if (ack_ok) st <= LD_WADDR;
                else begin fail <= 1'b1; st <= LD_STOP; end
              end
              LD_WADDR: begin
                if (ack_ok) st <= LD_START2;
                else begin fail <= 1'b1; st <= LD_STOP; end
              end
              LD_START2: st <= LD_DEVR;
              LD_DEVR: begin
                if (ack_ok) st <= LD_HDR;
                else begin fail <= 1'b1; st <= LD_STOP; end
              end
              LD_HDR: begin
                if (rx_byte == 8'h00) begin
                  idx <= '0;
                  st  <= LD_DATA;
                end else begin
                  fail <= 1'b1;
                  st   <= LD_STOP;
                end
              end
              LD_DATA: begin
                wr_en   <= 1'b1;
                wr_addr <= idx;
                wr_data <= rx_byte;
                if (last_idx) st <= LD_STOP;
                else          idx <= idx + 1'b1;
              end
              LD_STOP: begin
                if (fail) begin
                  idx <= '0;
                  st  <= LD_DEFS;
                end else begin
                  done <= 1'b1;
                  gap  <= '0;
                  st   <= LD_GAP;
                end
              end
              default: st <= LD_IDLE;
            endcase
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/cfg_rom_loader.sv
module cfg_rom_loader
  import cfg_ldr_pkg::*;
#(
  parameter int         NUM_REGS  = 16,
  parameter int         CLK_DIV   = 64,
  parameter int         GAP_CYC   = 1024,
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter logic [7:0] BASE_ADDR = 8'h80,
  parameter logic [7:0] DEF_SEED  = 8'hA5,
  localparam int        AW        = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold_i,
  input  logic          sda_i,
  output logic          scl_oe_o,
  output logic          sda_oe_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          done_o
);

  logic       tick;
  logic       cmd_vld;
  bus_op_e    cmd_op;
  logic [7:0] cmd_tx;
  logic       ack_drv;
  logic       bit_busy;
  logic       bit_done;
  logic [7:0] rx_byte;
  logic       ack_ok;

  cfg_ldr_tick #(.DIV(CLK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  cfg_ldr_bitio u_bit (
    .clk     (clk),
    .rst     (rst),
    .abort   (hold_i),
    .tick    (tick),
    .cmd_vld (cmd_vld),
    .cmd_op  (cmd_op),
    .cmd_tx  (cmd_tx),
    .ack_drv (ack_drv),
    .sda_in  (sda_i),
    .busy    (bit_busy),
    .done    (bit_done),
    .rx_byte (rx_byte),
    .ack_ok  (ack_ok),
    .scl_oe  (scl_oe_o),
    .sda_oe  (sda_oe_o)
  );

  cfg_ldr_seq #(
    .NUM_REGS  (NUM_REGS),
    .AW        (AW),
    .GAP_CYC   (GAP_CYC),
    .DEV_ADDR  (DEV_ADDR),
    .BASE_ADDR (BASE_ADDR),
    .DEF_SEED  (DEF_SEED)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .hold     (hold_i),
    .bit_busy (bit_busy),
    .bit_done (bit_done),
    .rx_byte  (rx_byte),
    .ack_ok   (ack_ok),
    .cmd_vld  (cmd_vld),
    .cmd_op   (cmd_op),
    .cmd_tx   (cmd_tx),
    .ack_drv  (ack_drv),
    .wr_en    (wr_en_o),
    .wr_addr  (wr_addr_o),
    .wr_data  (wr_data_o),
    .done     (done_o)
  );

endmodule

// File: rtl/cfg_ldr_chk.sv
module cfg_ldr_chk #(
  parameter int NUM_REGS = 16,
  parameter int AW       = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          hold_i,
  input logic          scl_oe_o,
  input logic          sda_oe_o,
  input logic          wr_en_o,
  input logic [AW-1:0] wr_addr_o,
  input logic          done_o
);

  // R8
  hold_release_chk: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> (!scl_oe_o && !sda_oe_o && !wr_en_o));

  // R9
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_i && $past(hold_i)) |-> (!wr_en_o && !scl_oe_o && !sda_oe_o));

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o);

  // R11
  wr_addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (32'(wr_addr_o) < NUM_REGS));

  // R6
  bus_free_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> (!scl_oe_o && !sda_oe_o));

endmodule

bind cfg_rom_loader cfg_ldr_chk #(.NUM_REGS(NUM_REGS), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .hold_i    (hold_i),
  .scl_oe_o  (scl_oe_o),
  .sda_oe_o  (sda_oe_o),
  .wr_en_o   (wr_en_o),
  .wr_addr_o (wr_addr_o),
  .done_o    (done_o)
);

// File: tb/tb_cfg_rom_loader.sv
module tb_cfg_rom_loader;

  localparam int         NR   = 6;
  localparam int         DIV  = 2;
  localparam int         GAP  = 40;
  localparam logic [7:0] SEED = 8'hA5;

  // {header[16:9], device_nak[8], fill_seed[7:0]}
  localparam logic [16:0] VEC [5] = '{
    {8'h00, 1'b0, 8'h10},
    {8'h3C, 1'b0, 8'h22},
    {8'h00, 1'b1, 8'h31},
    {8'hFF, 1'b0, 8'h47},
    {8'h00, 1'b0, 8'hC8}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hold = 1'b0;
  always #4 clk = ~clk;

  logic       scl_oe, sda_oe, wr_en, done;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic       s_drv = 1'b0;
  wire        scl_w = !scl_oe;
  wire        sda_w = !(sda_oe || s_drv);

  cfg_rom_loader #(
    .NUM_REGS (NR),
    .CLK_DIV  (DIV),
    .GAP_CYC  (GAP),
    .DEF_SEED (SEED)
  ) dut (
    .clk       (clk),
    .rst       (rst),
    .hold_i    (hold),
    .sda_i     (sda_w),
    .scl_oe_o  (scl_oe),
    .sda_oe_o  (sda_oe),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .done_o    (done)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Register file shadow and write bookkeeping
  logic [7:0] shadow [NR];
  int wr_cnt = 0;
  int ord_err = 0;
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NR; i++) shadow[i] <= 8'hEE;
      wr_cnt  <= 0;
      ord_err <= 0;
    end else if (wr_en) begin
      shadow[wr_addr] <= wr_data;
      wr_cnt <= wr_cnt + 1;
      if (int'(wr_addr) != (wr_cnt % NR)) ord_err <= ord_err + 1;
    end
  end

  // EEPROM model
  logic [7:0] mem [256];
  bit nak_dev = 1'b0;
  logic scl_q = 1'b1, sda_q = 1'b1;
  logic [3:0] bc = 4'd0;
  logic [7:0] sr = 8'h00, ptr = 8'h00, waddr_seen = 8'h00, byte_b;
  logic [2:0] sph = 3'd0;
  logic txm = 1'b0, ackp = 1'b0, saw_rd = 1'b0;
  int macks = 0, mnacks = 0, start_cnt = 0;

  always @(posedge clk) begin
    scl_q <= scl_w;
    sda_q <= sda_w;
    if (rst) begin
      s_drv <= 1'b0; bc <= 4'd0; sph <= 3'd0; txm <= 1'b0; ackp <= 1'b0;
      saw_rd <= 1'b0; macks <= 0; mnacks <= 0; start_cnt <= 0; waddr_seen <= 8'h00;
    end else if (scl_w && scl_q && sda_q && !sda_w) begin
      start_cnt <= start_cnt + 1;
      sph <= 3'd1; bc <= 4'd0; txm <= 1'b0; ackp <= 1'b0; s_drv <= 1'b0;
    end else if (scl_w && scl_q && !sda_q && sda_w) begin
      sph <= 3'd0; bc <= 4'd0; txm <= 1'b0; s_drv <= 1'b0;
    end else if (scl_w && !scl_q) begin
      if (bc < 4'd8) begin
        sr <= {sr[6:0], sda_w};
        bc <= bc + 4'd1;
        if (bc == 4'd7 && !txm) begin
          byte_b = {sr[6:0], sda_w};
          ackp <= 1'b0;
          case (sph)
            3'd1: begin
              if (byte_b[7:1] == 7'h50 && !nak_dev) begin
                ackp <= 1'b1;
                sph  <= byte_b[0] ? 3'd4 : 3'd2;
                if (byte_b[0]) saw_rd <= 1'b1;
              end else begin
                sph <= 3'd0;
              end
            end
            3'd2: begin ptr <= byte_b; waddr_seen <= byte_b; ackp <= 1'b1; sph <= 3'd3; end
            default: ;
          endcase
        end
      end else begin
        bc <= 4'd0;
        if (txm) begin
          if (!sda_w) begin macks <= macks + 1; ptr <= ptr + 8'd1; end
          else begin mnacks <= mnacks + 1; txm <= 1'b0; sph <= 3'd0; end
        end else if (sph == 3'd4 && ackp) begin
          txm <= 1'b1;
        end
      end
    end else if (!scl_w && scl_q) begin
      if (txm && bc < 4'd8)       s_drv <= !mem[ptr][3'(7 - int'(bc))];
      else if (!txm && bc == 4'd8) s_drv <= ackp;
      else                         s_drv <= 1'b0;
    end
  end

  function automatic logic [7:0] dflt(input int i);
    return SEED ^ 8'((i * 37) % 256);
  endfunction

  task automatic fill_mem(input logic [7:0] hdr, input logic [7:0] seed);
    for (int a = 0; a < 256; a++) mem[a] = seed ^ 8'(a);
    mem[8'h80] = hdr;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", wr_cnt, NR);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit ok;
    logic [7:0] hdr, seed, exp;
    bit nk, use_def;
    int snap, s0, cyc;

    // Table-driven loads
    for (int v = 0; v < 5; v++) begin
      hdr = VEC[v][16:9]; nk = VEC[v][8]; seed = VEC[v][7:0];
      fill_mem(hdr, seed);
      nak_dev = nk;
      hold = 1'b0;
      rst = 1'b1;
      repeat (4) @(negedge clk);
      if (v == 0) begin
        // R1 reset state
        chk(!scl_oe && !sda_oe, "R1 bus released in reset", {scl_oe, sda_oe}, 0);
        chk(!done && !wr_en, "R1 done/strobe low in reset", {done, wr_en}, 0);
      end
      rst = 1'b0;
      wait_done(ok);
      chk(ok, "R1 load completes after reset", ok, 1);
      @(posedge clk); @(negedge clk);
      hold = 1'b1;
      use_def = (hdr != 8'h00) || nk;
      for (int i = 0; i < NR; i++) begin
        exp = use_def ? dflt(i) : (seed ^ 8'(8'h81 + i));
        chk(shadow[i] == exp, nk ? "R5 default on missing ack" : (hdr != 0 ? "R4 default on bad header" : "R3 data from 0x81+k"),
            shadow[i], exp);
      end
      chk(wr_cnt == NR, "R7 all writes before done", wr_cnt, NR);
      chk(ord_err == 0, "R11 ascending single writes", ord_err, 0);
      if (!nk) begin
        chk(waddr_seen == 8'h80 && saw_rd, "R2 word address and read phase", waddr_seen, 8'h80);
        chk(macks == (use_def ? 0 : NR), "R6 master acks", macks, use_def ? 0 : NR);
        chk(mnacks == 1, "R6 final NACK", mnacks, 1);
      end else begin
        chk(start_cnt == 1 && macks == 0, "R5 stop after missing ack", start_cnt, 1);
      end
      repeat (10) @(negedge clk);
    end

    // R8: abort in the middle of the data phase
    fill_mem(8'h00, 8'h10);
    nak_dev = 1'b0;
    hold = 1'b0;
    do_reset();
    for (int c = 0; c < 6000 && wr_cnt < 2; c++) @(negedge clk);
    hold = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(!scl_oe && !sda_oe && !wr_en, "R8 released after hold", {scl_oe, sda_oe, wr_en}, 0);
    snap = wr_cnt;
    chk(snap < NR, "R8 abort landed mid-load", snap, NR - 1);
    repeat (1500) @(negedge clk);
    chk(wr_cnt == snap, "R8 no writes after abort", wr_cnt, snap);
    chk(!done, "R8 done stays low", done, 0);

    // R9: hold high from reset
    hold = 1'b1;
    do_reset();
    repeat (400) @(negedge clk);
    chk(wr_cnt == 0 && start_cnt == 0, "R9 quiet while held", wr_cnt + start_cnt, 0);
    chk(!done && !scl_oe && !sda_oe, "R9 bus untouched", {done, scl_oe, sda_oe}, 0);
    hold = 1'b0;
    wait_done(ok);
    chk(ok, "R9 load after hold falls", ok, 1);
    @(posedge clk); @(negedge clk);
    chk(shadow[NR-1] == (8'h10 ^ 8'(8'h81 + NR - 1)), "R9 loaded data", shadow[NR-1], 8'h10 ^ 8'(8'h81 + NR - 1));

    // R10: continuous reload with hold low
    s0 = start_cnt;
    cyc = 0;
    while (start_cnt == s0 && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc >= GAP && cyc < GAP + 40, "R10 gap before reload", cyc, GAP);
    for (int c = 0; c < 6000 && wr_cnt < 2 * NR; c++) @(negedge clk);
    chk(wr_cnt == 2 * NR, "R10 second load writes", wr_cnt, 2 * NR);
    chk(done, "R7 done sticky across reload", done, 1);
    chk(ord_err == 0, "R11 order across reload", ord_err, 0);
    hold = 1'b1;
    repeat (4) @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule